// File: doc/BRIEF.md
# Fracturable LUT Logic Element

This block is one configurable logic element of a programmable fabric. Eight data inputs feed a pool of small lookup tables: two 4-input tables and four 3-input tables, 64 truth-table bits in all. A 3-bit mode value sets how those tables are joined by 2:1 multiplexers. The result is either one or two logic functions of different sizes: two 4-input functions, a 5-input function paired with a 3-, 4- or 5-input function, one 6-input function, two 6-input functions sharing one truth table, or a 4-input result cascaded into a 3-input table. The larger functions come from Shannon expansion: the extra inputs steer multiplexers between table outputs.

The two function outputs also drive a one-bit full adder with carry in and carry out. The two function bits and the adder sum can each be captured in an output register. Every register has its own clock enable, and all of them share a synchronous clear. The 67 configuration bits are loaded through a serial shift port. The mode is sent first, then the truth table from bit 63 down to bit 0.

Top module: `flex_lut_cell`

## Requirements
- R1: Mode 0 (split quad): f0 = T[din[3:0]] and f1 = T[16 + din[7:4]], where T is the 64-bit truth table.
- R2: Mode 1 (five plus three): f0 = T[din[4:0]] and f1 = T[48 + din[7:5]].
- R3: Mode 2 (five plus four): f0 = T[din[4:0]] and f1 = T[48 + din[7:4]].
- R4: Mode 3 (five plus five): f0 = T[din[4:0]] and f1 = T[32 + {din[7:5], din[1:0]}]. Inputs din[1:0] are shared by both functions.
- R5: Mode 4 (single six): f0 = T[din[5:0]] and f1 is always 0.
- R6: Mode 5 (twin six): f0 = T[din[5:0]] and f1 = T[{din[7:6], din[3:0]}]. The two functions share din[3:0] and the truth table.
- R7: Mode 6 (chained): f0 = T[din[3:0]] and f1 = T[32 + {din[5], din[4], f0}].
- R8: Mode 7 is not a legal configuration. In that mode both function outputs are 0 for every input.
- R9: The adder outputs are combinational and satisfy {cout, sum_out} = f0 + f1 + cin.
- R10: q_out is {sum, f1, f0}. At each rising edge, a bit whose reg_ce bit is 1 loads its source value, and a bit whose enable is 0 keeps its value. reg_sclr clears all three bits and takes priority over the enables.
- R11: Synchronous reset clears the configuration to mode 0 with an all-zero truth table, and clears q_out. Both function outputs then read 0.
- R12: While cfg_shift is 1, each rising edge shifts cfg_sin into the configuration. After 67 shifts, the first bit sent is mode bit 2 and the last bit sent is T[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_sin | input | 1 | Serial configuration data |
| din | input | 8 | Logic data inputs |
| cin | input | 1 | Carry into the full adder |
| reg_ce | input | 3 | Clock enables for {sum, f1, f0} registers |
| reg_sclr | input | 1 | Synchronous clear of the output registers |
| f_out | output | 2 | Combinational function outputs {f1, f0} |
| sum_out | output | 1 | Combinational adder sum |
| cout | output | 1 | Combinational adder carry out |
| q_out | output | 3 | Registered {sum, f1, f0} |

## Verification
Two of this block's controls can act on the output registers in the same cycle: the synchronous clear and the clock enables. The bench holds every enable high while it raises reg_sclr. It judges the result by the registered outputs read one edge later, which must all be zero even though the enables asked for a load. The bench also uses a partial enable pattern to show that only the selected register takes the new function value while its neighbours keep their old ones.

// File: rtl/flut_pkg.sv
package flut_pkg;
  localparam int DIN_W  = 8;
  localparam int MODE_W = 3;
  localparam int TT_W   = 64;
  localparam int CFG_W  = TT_W + MODE_W;
  localparam int L4_N   = 2;
  localparam int L3_N   = 4;
  localparam int L4_K   = 4;
  localparam int L3_K   = 3;
  localparam int L4_BITS = 1 << L4_K;
  localparam int L3_BITS = 1 << L3_K;
  localparam int L3_BASE = L4_N * L4_BITS;

  typedef enum logic [MODE_W-1:0] {
    M_QUAD  = 3'd0,
    M_5P3   = 3'd1,
    M_5P4   = 3'd2,
    M_5P5   = 3'd3,
    M_SIX   = 3'd4,
    M_SIX2  = 3'd5,
    M_CHAIN = 3'd6,
    M_RSVD  = 3'd7
  } lut_mode_e;
endpackage

// File: rtl/flut_lut.sv
module flut_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] mask,
  input  logic [K-1:0]      addr,
  output logic              y
);
  assign y = mask[addr];
endmodule

// File: rtl/flut_cfg_chain.sv
module flut_cfg_chain #(
  parameter int W = 67
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (shift) cfg <= {cfg[W-2:0], sin};
  end
endmodule

// File: rtl/flut_fabric.sv
module flut_fabric
  import flut_pkg::*;
(
  input  logic [TT_W-1:0]  tt,
  input  lut_mode_e        mode,
  input  logic [DIN_W-1:0] d,
  output logic [1:0]       f
);
  logic [L4_N-1:0][L4_K-1:0] a4;
  logic [L3_N-1:0][L3_K-1:0] a3;
  logic [L4_N-1:0]           y4;
  logic [L3_N-1:0]           y3;
  logic [L3_K-1:0]           a3_common;
  logic [3:0]                g;
  logic                      f5;

  // 4-input table addresses: the second table takes the upper nibble only in split-quad mode
  assign a4[0] = d[3:0];
  assign a4[1] = (mode == M_QUAD) ? d[7:4] : d[3:0];

  always_comb begin
    unique case (mode)
      M_5P3:   a3_common = d[7:5];
      M_5P4:   a3_common = d[6:4];
      M_5P5:   a3_common = {d[5], d[1:0]};
      default: a3_common = d[2:0];
    endcase
    for (int j = 0; j < L3_N; j++) a3[j] = a3_common;
    if (mode == M_CHAIN) a3[0] = {d[5], d[4], y4[0]};
  end

  genvar gi;
  generate
    for (gi = 0; gi < L4_N; gi++) begin : g_l4
      flut_lut #(.K(L4_K)) u_lut (
        .mask (tt[gi*L4_BITS +: L4_BITS]),
        .addr (a4[gi]),
        .y    (y4[gi])
      );
    end
    for (gi = 0; gi < L3_N; gi++) begin : g_l3
      flut_lut #(.K(L3_K)) u_lut (
        .mask (tt[L3_BASE + gi*L3_BITS +: L3_BITS]),
        .addr (a3[gi]),
        .y    (y3[gi])
      );
    end
  endgenerate

  // four 4-input cofactors; pairs of 3-input tables widen by one input on d[3]
  assign g  = {d[3] ? y3[3] : y3[2], d[3] ? y3[1] : y3[0], y4[1], y4[0]};
  assign f5 = d[4] ? y4[1] : y4[0];

  always_comb begin
    unique case (mode)
      M_QUAD:  f = {y4[1], y4[0]};
      M_5P3:   f = {y3[2], f5};
      M_5P4:   f = {d[7] ? y3[3] : y3[2], f5};
      M_5P5:   f = {y3[d[7:6]], f5};
      M_SIX:   f = {1'b0, g[d[5:4]]};
      M_SIX2:  f = {g[d[7:6]], g[d[5:4]]};
      M_CHAIN: f = {y3[0], y4[0]};
      default: f = 2'b00;
    endcase
  end
endmodule

// File: rtl/flut_oreg.sv
module flut_oreg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclr,
  input  logic [W-1:0] ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gb;
  generate
    for (gb = 0; gb < W; gb++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || sclr) q[gb] <= 1'b0;
        else if (ce[gb]) q[gb] <= d[gb];
      end
    end
  endgenerate
endmodule

// File: rtl/flex_lut_cell.sv
module flex_lut_cell
  import flut_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift,
  input  logic             cfg_sin,
  input  logic [DIN_W-1:0] din,
  input  logic             cin,
  input  logic [2:0]       reg_ce,
  input  logic             reg_sclr,
  output logic [1:0]       f_out,
  output logic             sum_out,
  output logic             cout,
  output logic [2:0]       q_out
);
  logic [CFG_W-1:0] cfg;
  lut_mode_e        cfg_mode;
  logic [1:0]       fn;

  flut_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .shift (cfg_shift),
    .sin   (cfg_sin),
    .cfg   (cfg)
  );

  assign cfg_mode = lut_mode_e'(cfg[CFG_W-1 -: MODE_W]);

  flut_fabric u_fab (
    .tt   (cfg[TT_W-1:0]),
    .mode (cfg_mode),
    .d    (din),
    .f    (fn)
  );

  assign f_out   = fn;
  assign sum_out = fn[0] ^ fn[1] ^ cin;
  assign cout    = (fn[0] & fn[1]) | (cin & (fn[0] | fn[1]));

  flut_oreg #(.W(3)) u_oreg (
    .clk  (clk),
    .rst  (rst),
    .sclr (reg_sclr),
    .ce   (reg_ce),
    .d    ({sum_out, fn}),
    .q    (q_out)
  );
endmodule

// File: rtl/flex_lut_cell_chk.sv
module flex_lut_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic [1:0] f,
  input logic       cin,
  input logic       sum,
  input logic       cout,
  input logic [2:0] ce,
  input logic       sclr,
  input logic [2:0] q
);
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7) |-> (f == 2'b00));

  assert_single_six_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> !f[1]);

  assert_adder_sum_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ({cout, sum} == (2'(f[0]) + 2'(f[1]) + 2'(cin))));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    sclr |=> (q == 3'b000));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!sclr && ce == 3'b000) |=> $stable(q));

  assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (!sclr && ce == 3'b111) |=> (q == $past({sum, f})));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == 3'b000 && mode == 3'd0));
endmodule

bind flex_lut_cell flex_lut_cell_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .mode (cfg_mode),
  .f    (f_out),
  .cin  (cin),
  .sum  (sum_out),
  .cout (cout),
  .ce   (reg_ce),
  .sclr (reg_sclr),
  .q    (q_out)
);

// File: tb/flex_lut_cell_test.sv
`timescale 1ns/1ps
module flex_lut_cell_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_shift = 1'b0;
  logic       cfg_sin = 1'b0;
  logic [7:0] din = 8'h00;
  logic       cin = 1'b0;
  logic [2:0] reg_ce = 3'b000;
  logic       reg_sclr = 1'b0;
  logic [1:0] f_out;
  logic       sum_out;
  logic       cout;
  logic [2:0] q_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flex_lut_cell uut (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sin(cfg_sin),
    .din(din), .cin(cin), .reg_ce(reg_ce), .reg_sclr(reg_sclr),
    .f_out(f_out), .sum_out(sum_out), .cout(cout), .q_out(q_out)
  );

  localparam logic [63:0] TA = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [63:0] TB = 64'hC2B2_AE3D_27D4_EB4F;

  function automatic logic [1:0] model(input logic [2:0] m, input logic [63:0] t,
                                       input logic [7:0] d);
    logic e0, e1;
    e0 = 1'b0; e1 = 1'b0;
    case (m)
      3'd0: begin e0 = t[int'(d[3:0])]; e1 = t[16 + int'(d[7:4])]; end
      3'd1: begin e0 = t[int'(d[4:0])]; e1 = t[48 + int'(d[7:5])]; end
      3'd2: begin e0 = t[int'(d[4:0])]; e1 = t[48 + int'(d[7:4])]; end
      3'd3: begin e0 = t[int'(d[4:0])]; e1 = t[32 + int'({d[7:5], d[1:0]})]; end
      3'd4: begin e0 = t[int'(d[5:0])]; e1 = 1'b0; end
      3'd5: begin e0 = t[int'(d[5:0])]; e1 = t[int'({d[7:6], d[3:0]})]; end
      3'd6: begin e0 = t[int'(d[3:0])]; e1 = t[32 + int'({d[5], d[4], e0})]; end
      default: begin e0 = 1'b0; e1 = 1'b0; end
    endcase
    return {e1, e0};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load(input logic [2:0] m, input logic [63:0] t);
    logic [66:0] word;
    word = {m, t};
    for (int k = 66; k >= 0; k--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_sin   = word[k];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cfg_sin   = 1'b0;
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1 quad";
      3'd1: return "R2 5p3";
      3'd2: return "R3 5p4";
      3'd3: return "R4 5p5";
      3'd4: return "R5 six";
      3'd5: return "R6 twin six";
      3'd6: return "R7 chain";
      default: return "R8 reserved";
    endcase
  endfunction

  task automatic sweep(input logic [2:0] m, input logic [63:0] t);
    logic [1:0] e;
    logic [1:0] s;
    load(m, t);
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 2; c++) begin
        din = 8'(v);
        cin = c[0];
        #1;
        e = model(m, t, din);
        check(mode_tag(m), {6'd0, f_out}, {6'd0, e});
        s = 2'(e[0]) + 2'(e[1]) + 2'(cin);
        check("R9 adder", {6'd0, cout, sum_out}, {6'd0, s});
      end
    end
  endtask

  logic done = 1'b0;

  initial begin
    logic [1:0] e;
    logic [2:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    din = 8'hFF; #1;
    check("R11 reset f_out", {6'd0, f_out}, 8'h00);
    check("R11 reset q_out", {5'd0, q_out}, 8'h00);

    // R12: serial order, single marker bit at T[0] and mode 4
    load(3'd4, 64'h1);
    din = 8'h00; #1;
    check("R12 marker at T0", {6'd0, f_out}, 8'h01);
    din = 8'h01; #1;
    check("R12 marker absent", {6'd0, f_out}, 8'h00);
    // R12: marker at T[63] picks top entry only
    load(3'd4, 64'h8000_0000_0000_0000);
    din = 8'h3F; #1;
    check("R12 marker at T63", {6'd0, f_out}, 8'h01);

    // R1..R9: all modes over all inputs, two truth tables
    for (int m = 0; m < 8; m++) begin
      sweep(3'(m), TA);
      sweep(3'(m), TB);
    end

    // R10: register behaviour, mode 0 table TA
    load(3'd0, TA);
    @(negedge clk);
    din = 8'h5A; cin = 1'b1; reg_ce = 3'b111;
    e = model(3'd0, TA, 8'h5A);
    held = {e[0] ^ e[1] ^ 1'b1, e};
    @(negedge clk);
    reg_ce = 3'b000;
    check("R10 capture all", {5'd0, q_out}, {5'd0, held});
    din = 8'hA5; cin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold with enables low", {5'd0, q_out}, {5'd0, held});
    din = 8'hC3; cin = 1'b0; reg_ce = 3'b010;
    e = model(3'd0, TA, 8'hC3);
    @(negedge clk);
    reg_ce = 3'b000;
    check("R10 partial enable", {5'd0, q_out}, {5'd0, held[2], e[1], held[0]});
    // R10: clear and enables in the same cycle
    din = 8'hFF; cin = 1'b1; reg_ce = 3'b111; reg_sclr = 1'b1;
    @(negedge clk);
    reg_sclr = 1'b0; reg_ce = 3'b000;
    check("R10 clear beats enable", {5'd0, q_out}, 8'h00);

    // R11: reset after a configuration clears it
    load(3'd5, TB);
    din = 8'h00; reg_ce = 3'b111;
    @(negedge clk);
    reg_ce = 3'b000;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int v = 0; v < 256; v += 17) begin
      din = 8'(v); #1;
      check("R11 config cleared", {6'd0, f_out}, 8'h00);
    end
    check("R11 q cleared", {5'd0, q_out}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule